// File: doc/BRIEF.md
# Serial LCD Frame Receiver

This block takes a three-wire serial link (shift clock, data, load strobe) that has already been brought into the system clock domain. It assembles a 38-bit frame and acts on the six command bits at the tail of that frame each time the load strobe rises. One command copies the 32 data bits of the frame into one of four display row registers, with two select bits choosing the row. Two other commands switch the display off and back on. The row registers are kept while the display is off.

The three serial inputs are plain levels. The block samples them on `clk` and treats a low-to-high change seen between two samples as an event. There is no back-pressure: the sender must hold each level for at least one `clk` cycle. The row outputs give the stored row words when the display is enabled. They read zero while it is disabled.

Top module: `lcdrx_top`

## Requirements
- R1: Each rising edge of `ser_clk_i` shifts in one bit from `ser_dat_i`. The frame is sent as D1 first, then D2 to D32, then C0, C1, C2, C3, C4 and C5. After a data write, segment n of the selected row (bit n-1 of that row word) equals Dn, where 1 means the segment is lit.
- R2: The command code is the 4-bit value {C5,C4,C3,C2}. Code 4'b0001 writes the data bits into row {C1,C0}, where row r is bits [32r+31:32r] of `rows_o`. No other row changes.
- R3: Code 4'b1000 clears `disp_en_o` and forces all of `rows_o` to zero, whatever the row contents.
- R4: Code 4'b1001 sets `disp_en_o`. `rows_o` then shows the row contents as they were before, unchanged.
- R5: The off and on commands work when only the four bits C2 to C5 are shifted in before the load strobe.
- R6: Any other code value changes no row and does not change `disp_en_o`.
- R7: While `rst_n` is low, all rows clear to zero and the display is disabled.
- R8: Bits shifted in before a frame (leading dummy bits) have no effect on the command or data that the frame carries.
- R9: Each load pulse acts at most once, on its rising edge. Bits shifted while the strobe stays high are not acted on until the next rising edge.
- R10: Data written while the display is off is stored, and it appears on `rows_o` once the display is switched on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, sampled level |
| ser_dat_i | input | 1 | Serial data, sampled level |
| ser_ld_i | input | 1 | Load strobe, sampled level |
| rows_o | output | 128 | Four row words, row r at [32r+31:32r], zero while the display is off |
| disp_en_o | output | 1 | Display enabled |

## Verification
A shift clock level that is high at a `clk` rising edge moves the frame register on that same edge. The load strobe's rising edge is acted on at the first `clk` edge that samples it high, so `rows_o` and `disp_en_o` are updated right after that edge. The bench changes every input on a falling edge, holds each level for one full cycle, and compares the outputs on the falling edge after the load strobe was sampled. That sample point lies half a cycle after the update is due. The load-held test also checks the outputs while the strobe stays high and again after it drops, to show that no second write takes place.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] OP_WRITE = 4'b0001;
  localparam logic [CMD_W-1:0] OP_OFF   = 4'b1000;
  localparam logic [CMD_W-1:0] OP_ON    = 4'b1001;

  typedef enum logic [1:0] {ACT_NONE, ACT_WRITE, ACT_OFF, ACT_ON} act_e;

  function automatic act_e classify(input logic [CMD_W-1:0] code);
    case (code)
      OP_WRITE: return ACT_WRITE;
      OP_OFF:   return ACT_OFF;
      OP_ON:    return ACT_ON;
      default:  return ACT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/lcdrx_edge.sv
module lcdrx_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q;
  end
endmodule

// File: rtl/lcdrx_shift.sv
module lcdrx_shift #(
  parameter int W = 38
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         bit_i,
  output logic [W-1:0] frame_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frame_o <= '0;
    else if (step_i) frame_o <= {frame_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/lcdrx_ctrl.sv
module lcdrx_ctrl
  import lcdrx_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int SEL_W = 2,
  localparam int NROW    = 1 << SEL_W,
  localparam int FRAME_W = SEG_W + SEL_W + CMD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               load_i,
  output logic [NROW-1:0]    wr_o,
  output logic [SEG_W-1:0]   data_o,
  output logic               en_o
);
  // newest bit sits at frame_i[0]: C5 there, D1 at the top
  logic [CMD_W-1:0] code;
  logic [SEL_W-1:0] sel;
  act_e             act;
  logic             en_q;

  for (genvar j = 0; j < CMD_W; j++) begin : g_code
    assign code[j] = frame_i[CMD_W-1-j];
  end
  for (genvar k = 0; k < SEL_W; k++) begin : g_sel
    assign sel[k] = frame_i[CMD_W+SEL_W-1-k];
  end
  for (genvar i = 0; i < SEG_W; i++) begin : g_dat
    assign data_o[i] = frame_i[FRAME_W-1-i];
  end

  assign act = classify(code);

  always_comb begin
    wr_o = '0;
    if (load_i && act == ACT_WRITE) wr_o[sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (load_i && act == ACT_OFF) en_q <= 1'b0;
    else if (load_i && act == ACT_ON)  en_q <= 1'b1;
  end
  assign en_o = en_q;

  p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && code == OP_OFF) |=> !en_o);
  p_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && code == OP_ON) |=> en_o);
  p_unassigned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && code != OP_WRITE && code != OP_OFF && code != OP_ON) |=> $stable(en_o));
endmodule

// File: rtl/lcdrx_bank.sv
module lcdrx_bank #(
  parameter int SEG_W = 32,
  parameter int NROW  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NROW-1:0]            wr_i,
  input  logic [SEG_W-1:0]           data_i,
  output logic [NROW-1:0][SEG_W-1:0] rows_o
);
  for (genvar r = 0; r < NROW; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rows_o[r] <= '0;
      else if (wr_i[r]) rows_o[r] <= data_i;
    end
  end

  p_one_row_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_i));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_i) |=> $stable(rows_o));
endmodule

// File: rtl/lcdrx_top.sv
module lcdrx_top
  import lcdrx_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int SEL_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_clk_i,
  input  logic                        ser_dat_i,
  input  logic                        ser_ld_i,
  output logic [(SEG_W<<SEL_W)-1:0]   rows_o,
  output logic                        disp_en_o
);
  localparam int NROW    = 1 << SEL_W;
  localparam int FRAME_W = SEG_W + SEL_W + CMD_W;

  logic [1:0]                   rise;
  logic [FRAME_W-1:0]           frame;
  logic [NROW-1:0]              wr_vec;
  logic [SEG_W-1:0]             wdata;
  logic [NROW-1:0][SEG_W-1:0]   rows_q;
  logic                         en;

  lcdrx_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl_i({ser_ld_i, ser_clk_i}), .rise_o(rise)
  );

  lcdrx_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .step_i(rise[0]), .bit_i(ser_dat_i), .frame_o(frame)
  );

  lcdrx_ctrl #(.SEG_W(SEG_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_i(frame), .load_i(rise[1]),
    .wr_o(wr_vec), .data_o(wdata), .en_o(en)
  );

  lcdrx_bank #(.SEG_W(SEG_W), .NROW(NROW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_vec), .data_i(wdata), .rows_o(rows_q)
  );

  assign rows_o    = en ? rows_q : '0;
  assign disp_en_o = en;

  p_write_needs_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_vec) |-> ser_ld_i);
  p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_vec) |=> !(|wr_vec));
endmodule

// File: tb/test_lcdrx_top.sv
module test_lcdrx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sld = 1'b0;
  logic [127:0] rows;
  logic en;
  int checks = 0, errors = 0;
  logic [31:0] exp_row [4];
  logic exp_en;
  bit done = 0;

  always #4 clk = ~clk;

  lcdrx_top i_lcdrx_top (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_ld_i(sld),
    .rows_o(rows), .disp_en_o(en)
  );

  task automatic check(input string req);
    checks++;
    if (en !== exp_en) begin
      errors++;
      $display("FAIL %s enable actual=%0b expected=%0b", req, en, exp_en);
    end
    for (int r = 0; r < 4; r++) begin
      logic [31:0] want;
      checks++;
      want = exp_en ? exp_row[r] : 32'h0;
      if (rows[32*r +: 32] !== want) begin
        errors++;
        $display("FAIL %s row%0d actual=%h expected=%h", req, r, rows[32*r +: 32], want);
      end
    end
  endtask

  task automatic shift_bit(input logic b);
    sdat = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_load;
    sld = 1'b1; @(negedge clk); sld = 1'b0; @(negedge clk);
  endtask

  // D1..D32 from data[0..31], then C0,C1 from sel, then C2..C5 from code[0..3]
  task automatic shift_frame(input logic [31:0] d, input logic [1:0] sel, input logic [3:0] code);
    for (int i = 0; i < 32; i++) shift_bit(d[i]);
    shift_bit(sel[0]); shift_bit(sel[1]);
    for (int i = 0; i < 4; i++) shift_bit(code[i]);
  endtask

  task automatic short_cmd(input logic [3:0] code);
    for (int i = 0; i < 4; i++) shift_bit(code[i]);
    pulse_load();
  endtask

  task automatic t_reset;  // R7
    exp_en = 0;
    check("R7 reset");
    short_cmd(4'b1001); exp_en = 1;
    check("R7 rows cleared");
  endtask

  task automatic t_write_rows;  // R1 R2
    logic [31:0] pat [4];
    pat[0] = 32'h0000_0001; pat[1] = 32'h8000_0000;
    pat[2] = 32'hA5C3_0F12; pat[3] = 32'hFFFF_FFFF;
    for (int r = 0; r < 4; r++) begin
      shift_frame(pat[r], r[1:0], 4'b0001); pulse_load();
      exp_row[r] = pat[r];
      check(r == 0 ? "R1 D1 maps to bit0" : "R2 row select");
    end
  endtask

  task automatic t_off_on;  // R3 R4 R5
    short_cmd(4'b1000); exp_en = 0;
    check("R3 display off blanks");
    short_cmd(4'b1001); exp_en = 1;
    check("R4 display on restores");
    shift_frame(32'h1234_5678, 2'b11, 4'b1000); pulse_load(); exp_en = 0;
    check("R5 off with full frame");
    short_cmd(4'b1001); exp_en = 1;
    check("R5 on with short frame");
  endtask

  task automatic t_unassigned;  // R6
    logic [3:0] bad [5];
    bad[0] = 4'b0000; bad[1] = 4'b0010; bad[2] = 4'b0111; bad[3] = 4'b1010; bad[4] = 4'b1111;
    for (int k = 0; k < 5; k++) begin
      shift_frame(32'hDEAD_BEEF, k[1:0], bad[k]); pulse_load();
      check("R6 unassigned code ignored");
    end
    short_cmd(4'b1000); exp_en = 0;
    shift_frame(32'h0, 2'b00, 4'b1011); pulse_load();
    check("R6 unassigned code keeps off");
    short_cmd(4'b1001); exp_en = 1;
  endtask

  task automatic t_dummy;  // R8
    for (int i = 0; i < 7; i++) shift_bit(i[0]);
    shift_frame(32'h0F0F_3C3C, 2'b10, 4'b0001); pulse_load();
    exp_row[2] = 32'h0F0F_3C3C;
    check("R8 leading dummy bits");
  endtask

  task automatic t_hold_load;  // R9
    shift_frame(32'h1111_2222, 2'b01, 4'b0001);
    sld = 1'b1; @(negedge clk);
    exp_row[1] = 32'h1111_2222;
    check("R9 write on load rise");
    shift_frame(32'h3333_4444, 2'b01, 4'b0001);
    check("R9 no write while load held");
    sld = 1'b0; @(negedge clk); @(negedge clk);
    check("R9 no write on load fall");
    pulse_load(); exp_row[1] = 32'h3333_4444;
    check("R9 next rise writes");
  endtask

  task automatic t_write_while_off;  // R10
    short_cmd(4'b1000); exp_en = 0;
    shift_frame(32'h7E7E_0101, 2'b00, 4'b0001); pulse_load();
    exp_row[0] = 32'h7E7E_0101;
    check("R10 stays blank while off");
    short_cmd(4'b1001); exp_en = 1;
    check("R10 stored data shown on enable");
  endtask

  initial begin
    for (int r = 0; r < 4; r++) exp_row[r] = '0;
    exp_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_rows();
    t_off_on();
    t_unassigned();
    t_dummy();
    t_hold_load();
    t_write_while_off();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule